// File: doc/BRIEF.md
# Multi-Precision Reconfigurable Multiplier Array

This block holds a pool of nine signed 8x8 multiplier units, and a mode code regroups the pool at run time. In the narrow mode each unit serves its own lane, so nine 8x8 products come out together. In the medium mode up to three 16x16 products are formed. In the wide mode a single 32x32 product is formed. Each unit recodes its multiplier operand into radix-4 Booth digits and sums the partial products in carry-save form. The wide products are built by cutting the operands into 8-bit slices. Each unit multiplies one pair of slices. A regular shift-and-add structure then sums the slice products of each lane.

A 32x32 product needs sixteen slice products, and three 16x16 products need twelve. Both exceed the nine units, so the work is spread over two passes. The first pass is held in an accumulator. A 16x16 job that leaves lane 2 disabled fits in one pass. Each unit has its own operand registers. These registers load only when the unit has work in the current pass, so idle units do not toggle. Each transaction starts with a one-cycle start pulse taken while the block is idle. The result appears on the shared product bus with a one-cycle done pulse.

Top module: `mpm_array`

## Requirements
- R1: Mode code 0 gives nine signed 8x8 lanes. Lane k multiplies op_a[8k+7:8k] by op_b[8k+7:8k] as two's complement and places the 16-bit product on prod[16k+15:16k].
- R2: Mode code 1 gives three signed 16x16 lanes. Lane k (0..2) takes op_a[16k+15:16k] and op_b[16k+15:16k] and places the 32-bit product on prod[32k+31:32k].
- R3: Mode code 2 gives one signed 32x32 lane. It takes op_a[31:0] and op_b[31:0] and places the 64-bit product on prod[63:0].
- R4: Mode code 3 behaves exactly as mode code 0.
- R5: A start that is accepted at clock edge N raises done for exactly one cycle. Done follows edge N+1 in mode 0 and in mode 1 when lane_en[2] is clear. Done follows edge N+2 in mode 2 and in mode 1 when lane_en[2] is set.
- R6: busy is high from the accepting edge until the edge that raises done. A start seen while busy is ignored and does not alter the running job.
- R7: mode, lane_en, op_a and op_b are sampled only at the accepting edge. Changes to them afterwards do not affect the result.
- R8: Product bits of lanes whose lane_en bit is clear are zero. Bits above the lanes that the mode defines are also zero (above bit 95 in mode 1, above bit 63 in mode 2).
- R9: A unit that has no work in the current pass keeps its operand registers unchanged. This covers units serving disabled lanes, units beyond the lane count, and units left over in the second pass.
- R10: Reset clears prod, done and busy. prod holds its value until the next done, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, accepted when idle |
| mode | input | 2 | Precision code: 0 = 8x8, 1 = 16x16, 2 = 32x32, 3 = 8x8 |
| lane_en | input | 9 | Lane enables, bit k for lane k |
| op_a | input | 72 | Multiplicand lanes, packed from bit 0 |
| op_b | input | 72 | Multiplier lanes, packed from bit 0 |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle result strobe |
| prod | output | 144 | Product lanes, packed from bit 0 |

## Verification
The bench builds the block with its defaults: 8-bit slices and nine units. With these values both two-pass cases can be reached: the 32x32 job and the 16x16 job whose third lane spills into the second pass. A 16x16 job limited to lanes 0 and 1 can also be reached, and it finishes in one pass. The corners of every slice combination are covered by using the most negative and most positive operand of each width. These corners exercise the signed slice multiplies (upper slices) and the unsigned slice multiplies (lower slices) on the same runs.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

  localparam int LANE_BITS = 4;

  typedef enum logic [1:0] {
    PREC_8  = 2'd0,
    PREC_16 = 2'd1,
    PREC_32 = 2'd2
  } prec_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PASS0 = 2'd1,
    ST_PASS1 = 2'd2
  } phase_e;

  // one slice multiply: which lane, which slices, signedness of each slice
  typedef struct packed {
    logic                 vld;
    logic [LANE_BITS-1:0] lane;
    logic [1:0]           si;
    logic [1:0]           sj;
    logic                 a_sgn;
    logic                 b_sgn;
  } job_t;

  function automatic prec_e decode_prec(input logic [1:0] code);
    case (code)
      2'd1:    return PREC_16;
      2'd2:    return PREC_32;
      default: return PREC_8;
    endcase
  endfunction

  function automatic int slices_of(input prec_e p);
    case (p)
      PREC_16: return 2;
      PREC_32: return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/mpm_booth_unit.sv
module mpm_booth_unit #(
  parameter int SW = 8
) (
  input  logic [SW-1:0]   a,
  input  logic [SW-1:0]   b,
  input  logic            a_sgn,
  input  logic            b_sgn,
  output logic [2*SW+1:0] p
);
  localparam int EW = SW + 2;     // even extended width
  localparam int ND = EW / 2;     // radix-4 digits
  localparam int RW = 2 * EW;     // partial product width
  localparam int PX = 2 * SW + 2;

  function automatic logic [RW-1:0] booth_pp(input logic [RW-1:0] m, input logic [2:0] trip);
    case (trip)
      3'b001, 3'b010: return m;
      3'b011:         return m << 1;
      3'b100:         return -(m << 1);
      3'b101, 3'b110: return -m;
      default:        return '0;
    endcase
  endfunction

  logic [EW-1:0] a_ext, b_ext;
  logic [EW:0]   b_pad;
  logic [RW-1:0] mcand, pp, s_vec, c_vec, t_vec, sum;

  always_comb begin
    a_ext = {{2{a_sgn & a[SW-1]}}, a};
    b_ext = {{2{b_sgn & b[SW-1]}}, b};
    b_pad = {b_ext, 1'b0};
    mcand = {{(RW-EW){a_ext[EW-1]}}, a_ext};
    s_vec = '0;
    c_vec = '0;
    t_vec = '0;
    pp    = '0;
    // carry-save reduction: one 3:2 compressor row per digit
    for (int i = 0; i < ND; i++) begin
      pp    = booth_pp(mcand, b_pad[2*i +: 3]) << (2*i);
      t_vec = s_vec ^ c_vec ^ pp;
      c_vec = ((s_vec & c_vec) | (s_vec & pp) | (c_vec & pp)) << 1;
      s_vec = t_vec;
    end
    sum = s_vec + c_vec;
    p   = sum[PX-1:0];
  end

endmodule

// File: rtl/mpm_sched.sv
module mpm_sched
  import mpm_pkg::*;
#(
  parameter int NU        = 9,
  parameter int MID_LANES = 3
) (
  input  mpm_pkg::prec_e          prec,
  input  logic                    pass,
  input  logic [NU-1:0]           en,
  output mpm_pkg::job_t [NU-1:0]  jobs
);
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      int q, lane_i, si_i, sj_i, nsl;
      logic v;
      q      = pass ? (NU + u) : u;
      nsl    = slices_of(prec);
      v      = 1'b0;
      lane_i = 0;
      si_i   = 0;
      sj_i   = 0;
      case (prec)
        PREC_16: begin
          v = (q < 4 * MID_LANES);
          if (v) begin
            lane_i = q / 4;
            si_i   = (q % 4) / 2;
            sj_i   = q % 2;
          end
        end
        PREC_32: begin
          v = (q < 16);
          if (v) begin
            si_i = q / 4;
            sj_i = q % 4;
          end
        end
        default: begin
          v      = !pass;
          lane_i = u;
        end
      endcase
      jobs[u].vld   = v && en[lane_i];
      jobs[u].lane  = LANE_BITS'(lane_i);
      jobs[u].si    = 2'(si_i);
      jobs[u].sj    = 2'(sj_i);
      jobs[u].a_sgn = (si_i == nsl - 1);
      jobs[u].b_sgn = (sj_i == nsl - 1);
    end
  end

endmodule

// File: rtl/mpm_combine.sv
module mpm_combine
  import mpm_pkg::*;
#(
  parameter int NU    = 9,
  parameter int SW    = 8,
  parameter int ACC_W = 64
) (
  input  mpm_pkg::job_t [NU-1:0]             jobs,
  input  logic [NU-1:0][2*SW+1:0]            p,
  output logic [NU-1:0][ACC_W-1:0]           lane_sum
);
  localparam int PX = 2 * SW + 2;

  always_comb begin
    for (int k = 0; k < NU; k++) begin
      lane_sum[k] = '0;
      for (int u = 0; u < NU; u++) begin
        if (jobs[u].vld && (int'(jobs[u].lane) == k)) begin
          lane_sum[k] = lane_sum[k] +
            ({{(ACC_W-PX){p[u][PX-1]}}, p[u]} << (SW * (int'(jobs[u].si) + int'(jobs[u].sj))));
        end
      end
    end
  end

endmodule

// File: rtl/mpm_array.sv
module mpm_array
  import mpm_pkg::*;
#(
  parameter int SW = 8,
  parameter int NU = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [NU-1:0]        lane_en,
  input  logic [NU*SW-1:0]     op_a,
  input  logic [NU*SW-1:0]     op_b,
  output logic                 busy,
  output logic                 done,
  output logic [2*NU*SW-1:0]   prod
);
  localparam int PW        = 2 * SW;
  localparam int PX        = 2 * SW + 2;
  localparam int MAXW      = 4 * SW;
  localparam int ACC_W     = 2 * MAXW;
  localparam int BUS_W     = NU * SW;
  localparam int OUT_W     = 2 * BUS_W;
  localparam int MID_LANES = NU / 3;

  phase_e                   state;
  prec_e                    prec_q;
  logic [NU-1:0]            en_q;
  logic                     two_pass_q;
  logic [BUS_W-1:0]         sa_q, sb_q;
  job_t [NU-1:0]            job_q;
  logic [NU-1:0][SW-1:0]    ua_q, ub_q;
  logic [MID_LANES-1:0][ACC_W-1:0] acc_q;
  logic [OUT_W-1:0]         prod_q;
  logic                     done_q;

  // named events
  logic accept, load_p1, finish;
  assign accept  = start && (state == ST_IDLE);
  assign load_p1 = (state == ST_PASS0) && two_pass_q;
  assign finish  = ((state == ST_PASS0) && !two_pass_q) || (state == ST_PASS1);

  prec_e prec_in;
  logic  two_pass_in;
  assign prec_in = decode_prec(mode);

  always_comb begin
    two_pass_in = (prec_in == PREC_32);
    if (prec_in == PREC_16) begin
      for (int k = 0; k < MID_LANES; k++) begin
        if (lane_en[k] && (4 * k + 3 >= NU)) two_pass_in = 1'b1;
      end
    end
  end

  // schedule for the pass about to load
  prec_e          sel_prec;
  logic           sel_pass;
  logic [NU-1:0]  sel_en;
  logic [BUS_W-1:0] src_a, src_b;
  job_t [NU-1:0]  jobs_nx;

  assign sel_prec = accept ? prec_in : prec_q;
  assign sel_pass = !accept;
  assign sel_en   = accept ? lane_en : en_q;
  assign src_a    = accept ? op_a : sa_q;
  assign src_b    = accept ? op_b : sb_q;

  mpm_sched #(.NU(NU), .MID_LANES(MID_LANES)) u_sched (
    .prec (sel_prec),
    .pass (sel_pass),
    .en   (sel_en),
    .jobs (jobs_nx)
  );

  logic [NU-1:0][SW-1:0] slice_a, slice_b;
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      int base;
      base = int'(jobs_nx[u].lane) * SW * slices_of(sel_prec);
      slice_a[u] = src_a[base + int'(jobs_nx[u].si) * SW +: SW];
      slice_b[u] = src_b[base + int'(jobs_nx[u].sj) * SW +: SW];
    end
  end

  // unit pool
  logic [NU-1:0][PX-1:0] u_p;
  for (genvar gu = 0; gu < NU; gu++) begin : g_unit
    mpm_booth_unit #(.SW(SW)) u_mul (
      .a     (ua_q[gu]),
      .b     (ub_q[gu]),
      .a_sgn (job_q[gu].a_sgn),
      .b_sgn (job_q[gu].b_sgn),
      .p     (u_p[gu])
    );

    logic signed [SW:0]   ref_a, ref_b;
    logic signed [PX-1:0] ref_p;
    assign ref_a = {job_q[gu].a_sgn & ua_q[gu][SW-1], ua_q[gu]};
    assign ref_b = {job_q[gu].b_sgn & ub_q[gu][SW-1], ub_q[gu]};
    assign ref_p = ref_a * ref_b;

    AST_UNIT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      u_p[gu] == ref_p); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !job_q[gu].vld |-> ($stable(ua_q[gu]) && $stable(ub_q[gu]))); // R9
  end

  logic [NU-1:0][ACC_W-1:0] lane_sum, total;

  mpm_combine #(.NU(NU), .SW(SW), .ACC_W(ACC_W)) u_comb (
    .jobs     (job_q),
    .p        (u_p),
    .lane_sum (lane_sum)
  );

  for (genvar gk = 0; gk < NU; gk++) begin : g_total
    if (gk < MID_LANES) begin : g_acc
      assign total[gk] = lane_sum[gk] + ((state == ST_PASS1) ? acc_q[gk] : '0);
    end else begin : g_pass
      assign total[gk] = lane_sum[gk];
    end
  end

  logic [OUT_W-1:0] assembled;
  always_comb begin
    assembled = '0;
    case (prec_q)
      PREC_32: assembled[ACC_W-1:0] = total[0];
      PREC_16: begin
        for (int k = 0; k < MID_LANES; k++) assembled[k*2*PW +: 2*PW] = total[k][2*PW-1:0];
      end
      default: begin
        for (int k = 0; k < NU; k++) assembled[k*PW +: PW] = total[k][PW-1:0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      prec_q     <= PREC_8;
      en_q       <= '0;
      two_pass_q <= 1'b0;
      sa_q       <= '0;
      sb_q       <= '0;
      job_q      <= '0;
      ua_q       <= '0;
      ub_q       <= '0;
      acc_q      <= '0;
      prod_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE:  if (accept) state <= ST_PASS0;
        ST_PASS0: state <= two_pass_q ? ST_PASS1 : ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
      if (accept) begin
        prec_q     <= prec_in;
        en_q       <= lane_en;
        two_pass_q <= two_pass_in;
        if (two_pass_in) begin
          sa_q <= op_a;
          sb_q <= op_b;
        end
      end
      if (accept || load_p1) begin
        job_q <= jobs_nx;
        for (int u = 0; u < NU; u++) begin
          if (jobs_nx[u].vld) begin
            ua_q[u] <= slice_a[u];
            ub_q[u] <= slice_b[u];
          end
        end
      end
      if (load_p1) begin
        for (int k = 0; k < MID_LANES; k++) acc_q[k] <= lane_sum[k];
      end
      if (finish) begin
        prod_q <= assembled;
        done_q <= 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = done_q;
  assign prod = prod_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5

  AST_PASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PASS1) |-> ($past(state) == ST_PASS0)); // R5

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(prec_q) && $stable(en_q))); // R6

  AST_WIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && prec_q == PREC_32) |-> (prod_q[OUT_W-1:ACC_W] == '0)); // R8

  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prod_q) |-> done_q); // R10

endmodule

// File: tb/mpm_array_tb.sv
`timescale 1ns/1ps
module mpm_array_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic [8:0]   lane_en = '0;
  logic [71:0]  op_a = '0;
  logic [71:0]  op_b = '0;
  logic         busy, done;
  logic [143:0] prod;

  int n_checks = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  mpm_array u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .lane_en(lane_en),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .prod(prod)
  );

  function automatic logic [143:0] ref_prod(input logic [1:0] m, input logic [8:0] en,
                                            input logic [71:0] a, input logic [71:0] b);
    logic [143:0] r;
    r = '0;
    if (m == 2'd2) begin
      if (en[0]) begin
        longint x, y;
        x = longint'($signed(a[31:0]));
        y = longint'($signed(b[31:0]));
        r[63:0] = x * y;
      end
    end else if (m == 2'd1) begin
      for (int k = 0; k < 3; k++) begin
        if (en[k]) begin
          int x, y;
          x = int'($signed(a[16*k +: 16]));
          y = int'($signed(b[16*k +: 16]));
          r[32*k +: 32] = x * y;
        end
      end
    end else begin
      for (int k = 0; k < 9; k++) begin
        if (en[k]) begin
          int x, y, z;
          x = int'($signed(a[8*k +: 8]));
          y = int'($signed(b[8*k +: 8]));
          z = x * y;
          r[16*k +: 16] = z[15:0];
        end
      end
    end
    return r;
  endfunction

  task automatic chk_vec(input logic [143:0] act, input logic [143:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [71:0] rnd72();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[71:0];
  endfunction

  // one transaction; inputs are scrambled right after the accepting edge (R7)
  task automatic run(input logic [1:0] m, input logic [8:0] en, input logic [71:0] a,
                     input logic [71:0] b, input int exp_lat, input string tag);
    logic [143:0] exp;
    int lat;
    exp = ref_prod(m, en, a, b);
    @(negedge clk);
    mode = m; lane_en = en; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode = ~m; lane_en = ~en; op_a = ~a; op_b = ~b;
    lat = 1;
    chk_int(int'(busy), 1, {tag, " R6 busy after start"});
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    chk_int(lat, exp_lat, {tag, " R5 latency"});
    chk_vec(prod, exp, {tag, " product"});
    @(negedge clk);
    chk_int(int'(done), 0, {tag, " R5 done is one cycle"});
  endtask

  task automatic t_reset();
    chk_int(int'(done), 0, "R10 reset done");
    chk_int(int'(busy), 0, "R10 reset busy");
    chk_vec(prod, '0, "R10 reset prod");
  endtask

  task automatic t_mode8();
    logic [71:0] a, b;
    // extremes spread over the lanes: min*min, min*max, max*max, -1*-1, 0*min, ...
    a = {8'h80, 8'h7F, 8'hFF, 8'h00, 8'h80, 8'h01, 8'hFF, 8'h7F, 8'h80};
    b = {8'h7F, 8'h80, 8'hFF, 8'h80, 8'h01, 8'h80, 8'h01, 8'h7F, 8'h80};
    run(2'd0, 9'h1FF, a, b, 2, "R1 extremes");
    for (int i = 0; i < 4; i++) run(2'd0, 9'h1FF, rnd72(), rnd72(), 2, "R1 random");
    run(2'd0, 9'h0A5, rnd72(), rnd72(), 2, "R8 R9 partial lanes 8x8");
  endtask

  task automatic t_mode16();
    logic [71:0] a, b;
    a = '0; b = '0;
    a[47:0] = {16'h8000, 16'h7FFF, 16'h8000};
    b[47:0] = {16'h7FFF, 16'h7FFF, 16'h8000};
    run(2'd1, 9'h007, a, b, 3, "R2 extremes");
    a[47:0] = {16'hFFFF, 16'h00FF, 16'h80FF};
    b[47:0] = {16'h0001, 16'hFF00, 16'h7F01};
    run(2'd1, 9'h007, a, b, 3, "R2 slice borders");
    for (int i = 0; i < 3; i++) run(2'd1, 9'h1FF, rnd72(), rnd72(), 3, "R2 R8 random");
    run(2'd1, 9'h003, rnd72(), rnd72(), 2, "R2 R5 two lanes single pass");
    run(2'd1, 9'h004, rnd72(), rnd72(), 3, "R8 R9 lane 2 only");
  endtask

  task automatic t_mode32();
    logic [71:0] a, b;
    a = rnd72(); b = rnd72();
    a[31:0] = 32'h8000_0000; b[31:0] = 32'h8000_0000;
    run(2'd2, 9'h1FF, a, b, 3, "R3 R8 min*min");
    a[31:0] = 32'h8000_0000; b[31:0] = 32'h7FFF_FFFF;
    run(2'd2, 9'h001, a, b, 3, "R3 min*max");
    a[31:0] = 32'h7FFF_FFFF; b[31:0] = 32'h7FFF_FFFF;
    run(2'd2, 9'h001, a, b, 3, "R3 max*max");
    a[31:0] = 32'hFFFF_FFFF; b[31:0] = 32'h0000_0001;
    run(2'd2, 9'h001, a, b, 3, "R3 -1*1");
    for (int i = 0; i < 3; i++) run(2'd2, 9'h001, rnd72(), rnd72(), 3, "R3 R7 random");
    run(2'd2, 9'h000, rnd72(), rnd72(), 3, "R8 lane disabled 32x32");
  endtask

  task automatic t_reserved();
    run(2'd3, 9'h1FF, rnd72(), rnd72(), 2, "R4 code 3 as 8x8");
    run(2'd3, 9'h111, rnd72(), rnd72(), 2, "R4 code 3 partial");
  endtask

  task automatic t_busy();
    logic [71:0] a, b;
    logic [143:0] exp;
    int lat;
    a = rnd72(); b = rnd72();
    exp = ref_prod(2'd2, 9'h001, a, b);
    @(negedge clk);
    mode = 2'd2; lane_en = 9'h001; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    mode = 2'd0; lane_en = 9'h1FF; op_a = rnd72(); op_b = rnd72(); start = 1'b1;
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    chk_int(int'(busy), 1, "R6 busy during second pass");
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    chk_int(lat, 3, "R6 latency with start while busy");
    chk_vec(prod, exp, "R6 start while busy ignored");
    @(negedge clk);
    chk_int(int'(done), 0, "R6 no second done");
    chk_int(int'(busy), 0, "R6 idle after done");
  endtask

  task automatic t_hold();
    logic [143:0] held;
    run(2'd0, 9'h1FF, rnd72(), rnd72(), 2, "R10 setup");
    held = prod;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      mode = 2'(i); lane_en = 9'h1FF; op_a = rnd72(); op_b = rnd72();
    end
    @(negedge clk);
    chk_vec(prod, held, "R10 prod held without start");
    chk_int(int'(done), 0, "R10 no done without start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mode8();
    t_mode16();
    t_mode32();
    t_reserved();
    t_busy();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule